// File: doc/BRIEF.md
# Multiplexed Synchronous Bus Slave

This block answers a host processor on a 16-bit bus that carries address and data on the same wires, clocked by a burst clock the host supplies. Every access opens with chip select and the address-latch strobe both low while the host drives a 16-bit address. One 32-bit word then moves as two 16-bit beats, the low half first. On writes the host drives both beats. On reads the host releases the bus, and the slave holds an active-low wait line until it has data, then returns the word.

The address splits into three fields. The upper twelve bits are a segment number that must equal the `SEG_ID` parameter. Bits 3:2 select one of four registers. The two lowest bits are ignored. On the fabric side the block drives a plain register port: a register index, a single-cycle write strobe carrying the whole 32-bit word, and a single-cycle read request. The user logic answers the read request with a data-valid flag at any later cycle. The whole block runs in the burst-clock domain.

Top module: `mux_bus_slave`

## Requirements
- R1: While reset is asserted, `wait_no` is high and `bus_oe_o`, `reg_we_o` and `reg_re_o` are low.
- R2: A write access is marked by `we_ni` low at the address beat. The low data half is sampled on the next burst-clock edge and the high half on the edge after that. In the cycle that follows the high-beat edge, `reg_we_o` pulses for exactly one cycle with `reg_wdata_o` = {high, low} and `reg_addr_o` = address bits 3:2.
- R3: If chip select rises before the high data beat is sampled, the access is dropped, no `reg_we_o` pulse is issued and the block returns to idle.
- R4: If address bits 15:4 differ from `SEG_ID`, the block issues neither `reg_we_o` nor `reg_re_o`, and a read returns zero in both halves.
- R5: A read access is marked by `we_ni` high at the address beat. In the cycle after the address beat, `reg_re_o` pulses for one cycle and `reg_addr_o` holds address bits 3:2.
- R6: On a read, `wait_no` goes low in the cycle after the address beat. It rises at the first edge that satisfies both of these: data is valid (on `reg_rvalid_i` at or before that edge), and at least `MIN_WAIT` cycles of low wait have passed.
- R7: In the first cycle with `wait_no` high, `bus_o` carries the low 16 bits of the read word. In the next cycle it carries the high 16 bits.
- R8: `bus_oe_o` is high only while chip select and output enable are both low during a read access. It is low during writes and low once the host raises output enable.
- R9: `wait_no` stays high throughout a write access.
- R10: Read data delivered several cycles after `reg_re_o` is held until it is returned. The wait time stretches to match the delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk_i | input | 1 | Host burst clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| adv_ni | input | 1 | Address-latch strobe, active low |
| we_ni | input | 1 | Write enable, active low, sampled with the address |
| oe_ni | input | 1 | Output enable, active low |
| bus_i | input | 16 | Shared bus as seen by the slave |
| bus_o | output | 16 | Value the slave places on the shared bus |
| bus_oe_o | output | 1 | Tri-state enable for `bus_o` |
| wait_no | output | 1 | Wait, active low |
| reg_addr_o | output | 2 | Register index of the current access |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 32 | Write word |
| reg_re_o | output | 1 | One-cycle read request |
| reg_rdata_i | input | 32 | Read word from user logic |
| reg_rvalid_i | input | 1 | Read word valid |

## Verification
The assertions rely on a well-behaved host and user side. The host holds chip select low for the whole access, pulses the latch strobe only on the address beat, keeps write enable steady across the access, and lowers output enable only after the address beat. The user logic pulses `reg_rvalid_i` at most once for each `reg_re_o`. The bench's host tasks keep to exactly this sequence, including the cases where an access is cut short. Its user model returns one valid pulse per request, with a delay chosen per test.

// File: rtl/mbs_pkg.sv
`timescale 1ns / 1ps
package mbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_WR_END,
    ST_RD_WAIT,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_END
  } mbs_state_e;
endpackage

// File: rtl/mbs_ctrl.sv
`timescale 1ns / 1ps
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int SEG_W    = 12,
  parameter int IDX_W    = 2,
  parameter logic [SEG_W-1:0] SEG_ID = 'h321,
  parameter int MIN_WAIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             adv_ni,
  input  logic             we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic             rd_ready_i,
  output mbs_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hit_o,
  output logic             re_o,
  output logic             wait_no
);
  localparam int LSB_W = ADDR_W - SEG_W - IDX_W;
  localparam int CNT_W = $clog2(MIN_WAIT + 1);
  localparam logic [CNT_W-1:0] CNT_TGT = CNT_W'(MIN_WAIT - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  mbs_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             hit_q, re_q, wait_q;
  logic [CNT_W-1:0] cnt_q;
  logic             seg_match, start, release_rd;

  assign seg_match  = addr_i[ADDR_W-1 -: SEG_W] == SEG_ID;
  assign start      = !cs_ni && !adv_ni;
  assign release_rd = rd_ready_i && (cnt_q >= CNT_TGT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      hit_q   <= 1'b0;
      re_q    <= 1'b0;
      wait_q  <= 1'b1;
      cnt_q   <= '0;
    end else begin
      re_q <= 1'b0;
      if (cs_ni && state_q != ST_IDLE) begin
        // host ended or aborted the access
        state_q <= ST_IDLE;
        wait_q  <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start) begin
            idx_q <= addr_i[LSB_W +: IDX_W];
            hit_q <= seg_match;
            if (!we_ni) begin
              state_q <= ST_WR_LO;
            end else begin
              state_q <= ST_RD_WAIT;
              wait_q  <= 1'b0;
              cnt_q   <= '0;
              re_q    <= seg_match;
            end
          end
          ST_WR_LO:  state_q <= ST_WR_HI;
          ST_WR_HI:  state_q <= ST_WR_END;
          ST_WR_END: state_q <= ST_WR_END;
          ST_RD_WAIT: begin
            if (release_rd) begin
              state_q <= ST_RD_LO;
              wait_q  <= 1'b1;
            end else if (cnt_q != CNT_MAX) begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_RD_LO:  state_q <= ST_RD_HI;
          ST_RD_HI:  state_q <= ST_RD_END;
          ST_RD_END: state_q <= ST_RD_END;
          default:   state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign hit_o   = hit_q;
  assign re_o    = re_q;
  assign wait_no = wait_q;

  a_r5_re_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_q |=> !re_q);
  a_r5_re_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(re_q) |-> $past(!cs_ni && !adv_ni && we_ni));
  a_r6_release_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(wait_q) && state_q == ST_RD_LO) |-> $past(rd_ready_i));
  a_r9_no_wait_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_WR_LO, ST_WR_HI, ST_WR_END}) |-> wait_q);
  a_r7_hi_after_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_HI) |-> $past(state_q == ST_RD_LO));
endmodule

// File: rtl/mbs_wr_path.sv
`timescale 1ns / 1ps
module mbs_wr_path
  import mbs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mbs_state_e        state_i,
  input  logic              hit_i,
  input  logic              cs_ni,
  input  logic [DATA_W-1:0] bus_i,
  output logic              we_o,
  output logic [WORD_W-1:0] wdata_o
);
  logic [DATA_W-1:0] lo_q;
  logic              we_q;
  logic [WORD_W-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q    <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (state_i == ST_WR_LO) lo_q <= bus_i;
      if (state_i == ST_WR_HI && !cs_ni && hit_i) begin
        we_q    <= 1'b1;
        wdata_q <= {bus_i, lo_q};
      end
    end
  end

  assign we_o    = we_q;
  assign wdata_o = wdata_q;

  a_r2_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  a_r3_we_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |-> $past(!cs_ni && state_i == ST_WR_HI));
endmodule

// File: rtl/mbs_rd_path.sv
`timescale 1ns / 1ps
module mbs_rd_path
  import mbs_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mbs_state_e        state_i,
  input  logic              hit_i,
  input  logic              cs_ni,
  input  logic              oe_ni,
  input  logic              rvalid_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic              rd_ready_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);
  logic              got_q;
  logic [WORD_W-1:0] buf_q;
  logic              in_read;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q <= 1'b0;
      buf_q <= '0;
    end else if (state_i == ST_IDLE) begin
      got_q <= 1'b0;
      buf_q <= '0;
    end else if (state_i == ST_RD_WAIT && !got_q) begin
      // a miss completes with the cleared buffer
      if (!hit_i) begin
        got_q <= 1'b1;
      end else if (rvalid_i) begin
        got_q <= 1'b1;
        buf_q <= rdata_i;
      end
    end
  end

  assign rd_ready_o = got_q || (hit_i && rvalid_i);
  assign in_read    = state_i inside {ST_RD_WAIT, ST_RD_LO, ST_RD_HI, ST_RD_END};
  assign bus_oe_o   = in_read && !cs_ni && !oe_ni;

  always_comb begin
    unique case (state_i)
      ST_RD_LO: bus_o = buf_q[DATA_W-1:0];
      ST_RD_HI: bus_o = buf_q[WORD_W-1:DATA_W];
      default:  bus_o = '0;
    endcase
  end

  a_r10_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {ST_RD_LO, ST_RD_HI}) |-> got_q);
  a_r4_miss_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RD_LO && !hit_i) |-> buf_q == '0);
  a_r8_no_drive_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i inside {ST_WR_LO, ST_WR_HI, ST_WR_END}) |-> !bus_oe_o);
endmodule

// File: rtl/mux_bus_slave.sv
`timescale 1ns / 1ps
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SEG_W    = 12,
  parameter int IDX_W    = 2,
  parameter logic [SEG_W-1:0] SEG_ID = 'h321,
  parameter int MIN_WAIT = 2,
  localparam int WORD_W  = 2 * DATA_W
) (
  input  logic              bclk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              adv_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              wait_no,
  output logic [IDX_W-1:0]  reg_addr_o,
  output logic              reg_we_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  output logic              reg_re_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  input  logic              reg_rvalid_i
);
  mbs_state_e state;
  logic       hit, rd_ready;

  mbs_ctrl #(
    .ADDR_W(DATA_W), .SEG_W(SEG_W), .IDX_W(IDX_W),
    .SEG_ID(SEG_ID), .MIN_WAIT(MIN_WAIT)
  ) u_ctrl (
    .clk_i(bclk_i), .rst_ni(rst_ni),
    .cs_ni(cs_ni), .adv_ni(adv_ni), .we_ni(we_ni),
    .addr_i(bus_i), .rd_ready_i(rd_ready),
    .state_o(state), .idx_o(reg_addr_o), .hit_o(hit),
    .re_o(reg_re_o), .wait_no(wait_no)
  );

  mbs_wr_path #(.DATA_W(DATA_W)) u_wr (
    .clk_i(bclk_i), .rst_ni(rst_ni),
    .state_i(state), .hit_i(hit), .cs_ni(cs_ni), .bus_i(bus_i),
    .we_o(reg_we_o), .wdata_o(reg_wdata_o)
  );

  mbs_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk_i(bclk_i), .rst_ni(rst_ni),
    .state_i(state), .hit_i(hit), .cs_ni(cs_ni), .oe_ni(oe_ni),
    .rvalid_i(reg_rvalid_i), .rdata_i(reg_rdata_i),
    .rd_ready_o(rd_ready), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  a_r1_idle_after_reset: assert property (@(posedge bclk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (wait_no && !reg_we_o && !reg_re_o));
endmodule

// File: tb/mux_bus_slave_bench.sv
`timescale 1ns / 1ps
module mux_bus_slave_bench;
  localparam int MIN_W = 2;
  localparam logic [11:0] SEG = 12'h321;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out;
  logic        bus_oe, wait_n;
  logic [1:0]  reg_addr;
  logic        reg_we, reg_re;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic        reg_rvalid = 1'b0;

  int n_chk = 0, n_fail = 0, we_seen = 0, rsp_delay = 0;
  logic [33:0] wq[$];
  logic [31:0] exp_mem[4];
  logic [31:0] usr_mem[4];

  always #2.5 clk = ~clk;

  mux_bus_slave #(.SEG_ID(SEG), .MIN_WAIT(MIN_W)) u_mux_bus_slave (
    .bclk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .adv_ni(adv_n),
    .we_ni(we_n), .oe_ni(oe_n), .bus_i(bus_in), .bus_o(bus_out),
    .bus_oe_o(bus_oe), .wait_no(wait_n), .reg_addr_o(reg_addr),
    .reg_we_o(reg_we), .reg_wdata_o(reg_wdata), .reg_re_o(reg_re),
    .reg_rdata_i(reg_rdata), .reg_rvalid_i(reg_rvalid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  // monitor: pops expected writes and feeds the user register model
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      we_seen++;
      usr_mem[reg_addr] = reg_wdata;
      if (wq.size() == 0) begin
        chk(1'b0, "R2 unexpected write", {30'd0, reg_addr}, 32'd0);
      end else begin
        logic [33:0] e;
        e = wq.pop_front();
        chk(reg_addr == e[33:32], "R2 write index", {30'd0, reg_addr}, {30'd0, e[33:32]});
        chk(reg_wdata == e[31:0], "R2 write word", reg_wdata, e[31:0]);
      end
    end
  end

  // user side: answers each read request after rsp_delay cycles
  initial begin
    bit pend = 0;
    int left = 0;
    forever begin
      @(negedge clk);
      reg_rvalid = 1'b0;
      if (rst_n && reg_re) begin
        pend = 1;
        left = rsp_delay;
      end
      if (pend) begin
        if (left == 0) begin
          reg_rvalid = 1'b1;
          reg_rdata  = usr_mem[reg_addr];
          pend = 0;
        end else begin
          left--;
        end
      end
    end
  end

  task automatic do_write(input logic [11:0] seg, input logic [1:0] idx,
                          input logic [31:0] d, input int abort_at);
    int base = we_seen;
    bit hit = (seg == SEG);
    bit will = hit && abort_at == 0;
    if (will) begin
      wq.push_back({idx, d});
      exp_mem[idx] = d;
    end
    @(negedge clk);
    cs_n = 0; adv_n = 0; we_n = 0; bus_in = {seg, idx, 2'b00};
    @(negedge clk);
    adv_n = 1; bus_in = d[15:0];
    chk(wait_n == 1'b1, "R9 wait during write", {31'd0, wait_n}, 32'd1);
    chk(bus_oe == 1'b0, "R8 no drive in write", {31'd0, bus_oe}, 32'd0);
    if (abort_at == 1) cs_n = 1;
    if (abort_at != 1) begin
      @(negedge clk);
      bus_in = d[31:16];
      chk(wait_n == 1'b1, "R9 wait during write", {31'd0, wait_n}, 32'd1);
      if (abort_at == 2) cs_n = 1;
      @(negedge clk);
      if (abort_at == 0)
        chk(reg_we == will, "R2 strobe cycle", {31'd0, reg_we}, {31'd0, will});
    end
    cs_n = 1; we_n = 1; bus_in = '0;
    @(negedge clk);
    @(negedge clk);
    if (abort_at != 0) chk(we_seen == base, "R3 aborted write", we_seen - base, 32'd0);
    else if (!hit)     chk(we_seen == base, "R4 miss write", we_seen - base, 32'd0);
    else               chk(we_seen == base + 1, "R2 write count", we_seen - base, 32'd1);
  endtask

  task automatic do_read(input logic [11:0] seg, input logic [1:0] idx, input int dly);
    bit hit = (seg == SEG);
    logic [31:0] exp = hit ? exp_mem[idx] : 32'd0;
    int base_w = hit ? dly + 1 : 2;
    int exp_w = (base_w > MIN_W) ? base_w : MIN_W;
    int waits = 0;
    rsp_delay = dly;
    @(negedge clk);
    cs_n = 0; adv_n = 0; we_n = 1; oe_n = 1; bus_in = {seg, idx, 2'b00};
    @(negedge clk);
    adv_n = 1; oe_n = 0; bus_in = '0;
    chk(reg_re == hit, hit ? "R5 read request" : "R4 miss no request", {31'd0, reg_re}, {31'd0, hit});
    if (hit) chk(reg_addr == idx, "R5 read index", {30'd0, reg_addr}, {30'd0, idx});
    while (!wait_n && waits < 100) begin
      waits++;
      @(negedge clk);
    end
    chk(waits == exp_w, dly > 0 ? "R10 stretched wait" : "R6 wait length", waits, exp_w);
    chk(bus_oe == 1'b1, "R8 drive in read", {31'd0, bus_oe}, 32'd1);
    chk(bus_out == exp[15:0], hit ? "R7 low half" : "R4 miss low half", {16'd0, bus_out}, {16'd0, exp[15:0]});
    @(negedge clk);
    chk(bus_out == exp[31:16], hit ? "R7 high half" : "R4 miss high half", {16'd0, bus_out}, {16'd0, exp[31:16]});
    @(negedge clk);
    oe_n = 1;
    #1;
    chk(bus_oe == 1'b0, "R8 release on oe", {31'd0, bus_oe}, 32'd0);
    cs_n = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      exp_mem[i] = '0;
      usr_mem[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(wait_n == 1'b1, "R1 wait in reset", {31'd0, wait_n}, 32'd1);
    chk(bus_oe == 1'b0, "R1 bus released in reset", {31'd0, bus_oe}, 32'd0);
    chk(!reg_we && !reg_re, "R1 strobes in reset", {30'd0, reg_we, reg_re}, 32'd0);
    rst_n = 1;
    @(negedge clk);

    do_write(SEG, 2'd0, 32'hAA55_A5A5, 0);
    do_write(SEG, 2'd1, 32'h1122_1212, 0);
    do_read(SEG, 2'd0, 0);
    do_read(SEG, 2'd1, 4);
    do_write(SEG, 2'd3, 32'hDEAD_BEEF, 0);
    do_read(SEG, 2'd3, 1);
    do_write(SEG, 2'd2, 32'h5555_AAAA, 2);
    do_read(SEG, 2'd2, 0);
    do_write(SEG, 2'd2, 32'h0F0F_F0F0, 1);
    do_read(SEG, 2'd2, 2);
    do_write(12'h123, 2'd1, 32'h9999_8888, 0);
    do_read(12'h123, 2'd1, 0);
    do_read(SEG, 2'd1, 0);
    do_write(SEG, 2'd2, 32'h7E57_0001, 0);
    do_read(SEG, 2'd2, 7);

    chk(wq.size() == 0, "R2 pending writes", wq.size(), 32'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule